// File: doc/BRIEF.md
# Adaptive Delta Modulation Codec

This block is a digital model of a one-bit delta-modulation coder and its matching decoder, meant for the two ends of an audio delay line. On each enabled sample tick the encoder checks the signed input sample against its own running estimate. It latches a single bit: 1 when the sample has reached or passed the estimate, and 0 when the sample is below it. The estimate then steps up on a 1 and down on a 0.

The decoder receives the bit stream and rebuilds the same estimate with an identical integrator. Both sides keep the last four bits. When those four bits are all equal the step size doubles on each tick, so a steep signal is tracked faster. When the bits are mixed the step halves on each tick, back toward the minimum. The decoder applies the same rule, so a decoder fed the same bits on the same ticks holds exactly the encoder's estimate. The storage between the two ends lies outside the block. Here, `encBit` is brought out and `decBitIn` is brought in.

The system clock runs all the time. A sample-enable input sets the effective sample rate. Both integrators are 16-bit signed accumulators that saturate at their limits instead of wrapping.

Top module: `adm_codec`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets both estimates to 0 and `encBit` to 0. It sets the four-bit history to the alternating pattern 0101, newest bit in bit 0. It sets the step to its minimum (16 by default).
- R2: On every rising clock edge with `sampleEn` high, `encBit` becomes 1 if the signed `sampleIn` is greater than or equal to the signed `encEstimate` before that edge, and 0 otherwise.
- R3: On an enabled tick, a 1 bit raises an estimate by the current step and a 0 bit lowers it by the current step, apart from clamping.
- R4: After an enabled tick, if the newest four bits (including this tick's bit) are all equal, the step doubles. The step never exceeds 16 times the minimum (256 by default).
- R5: After an enabled tick, if the newest four bits are not all equal, the step halves. The step never goes below the minimum.
- R6: An estimate saturates at +32767 and -32768 and never wraps around.
- R7: While `sampleEn` is low, the following keep their values and `decBitIn` is ignored: `encBit`, both estimates, both histories and both step sizes.
- R8: A decoder that receives on `decBitIn` the same bit the encoder decides on the same enabled tick has a `decOut` equal to `encEstimate` after every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Sample-tick enable that qualifies every update |
| sampleIn | input | 16 | Signed input sample for the encoder |
| decBitIn | input | 1 | Received bit for the decoder |
| encBit | output | 1 | Latched encoder output bit |
| encEstimate | output | 16 | Signed encoder integrator estimate |
| decOut | output | 16 | Signed decoder reconstructed output |

## Verification
The embedded properties check several rules on every cycle:
- the step only moves by one binary power per tick and stays at or below its ceiling;
- an enabled 1 never lowers an estimate and an enabled 0 never raises it;
- a positive estimate never turns negative on an up step, and a negative one never turns positive on a down step;
- nothing moves while the enable is low;
- the latched bit matches the comparison made on the previous edge.

The bench scenarios are needed for the exact step sizes: growth after a run, decay after mixed bits, the values reached at each clamp, and whether the decoder stays in lockstep with the encoder across a mixed stream.

// File: rtl/adm_pkg.sv
package adm_pkg;
  // Width of the step exponent (step = minimum << exponent)
  localparam int SHIFT_W = 3;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic               upd;    // enabled tick: apply an update
    logic               up;     // direction: 1 raises, 0 lowers
    logic [SHIFT_W-1:0] shift;  // current step exponent
  } stepCmd_t;
endpackage

// File: rtl/adm_step_ctrl.sv
module adm_step_ctrl
  import adm_pkg::*;
#(
  parameter int MAX_SHIFT = 4,
  parameter int HIST_LEN  = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     bitIn,
  output stepCmd_t cmd
);
  localparam logic [SHIFT_W-1:0] SHIFT_CAP = SHIFT_W'(MAX_SHIFT);

  function automatic logic [HIST_LEN-1:0] altPattern();
    logic [HIST_LEN-1:0] r;
    for (int i = 0; i < HIST_LEN; i++) r[i] = (i % 2 == 0);
    return r;
  endfunction
  localparam logic [HIST_LEN-1:0] HIST_RST = altPattern();

  logic [HIST_LEN-1:0] histQ, histNext;
  logic [SHIFT_W-1:0]  shiftQ;
  logic                runFlag;

  always_comb begin
    histNext = {histQ[HIST_LEN-2:0], bitIn};
    runFlag  = (&histNext) | ~(|histNext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      histQ  <= HIST_RST;
      shiftQ <= '0;
    end else if (en) begin
      histQ <= histNext;
      if (runFlag) begin
        if (shiftQ < SHIFT_CAP) shiftQ <= shiftQ + 1'b1;
      end else if (shiftQ != '0) begin
        shiftQ <= shiftQ - 1'b1;
      end
    end
  end

  always_comb begin
    cmd.upd   = en;
    cmd.up    = bitIn;
    cmd.shift = shiftQ;
  end

  // R4: step exponent never passes its ceiling
  p_shift_cap_r4: assert property (@(posedge clk) disable iff (rst)
    shiftQ <= SHIFT_CAP);

  // R5: step moves by at most one binary power per tick
  p_shift_slew_r5: assert property (@(posedge clk) disable iff (rst)
    en |=> (shiftQ == $past(shiftQ)) || (shiftQ == $past(shiftQ) + 1'b1)
        || (shiftQ == $past(shiftQ) - 1'b1));

  // R7: history and step frozen while disabled
  p_hold_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(shiftQ) && $stable(histQ));
endmodule

// File: rtl/adm_integ.sv
module adm_integ
  import adm_pkg::*;
#(
  parameter int W        = 16,
  parameter int STEP_MIN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  stepCmd_t            cmd,
  output logic signed [W-1:0] est
);
  localparam logic signed [W:0] POS_LIM = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] NEG_LIM = {2'b11, {(W-1){1'b0}}};
  localparam logic signed [W:0] BASE    = (W+1)'(STEP_MIN);

  logic signed [W-1:0] estQ;
  logic signed [W:0]   stepVal, sum;
  logic signed [W-1:0] estNext;

  always_comb begin
    stepVal = BASE <<< cmd.shift;
    sum     = cmd.up ? ({estQ[W-1], estQ} + stepVal)
                     : ({estQ[W-1], estQ} - stepVal);
    if (sum > POS_LIM)      estNext = POS_LIM[W-1:0];
    else if (sum < NEG_LIM) estNext = NEG_LIM[W-1:0];
    else                    estNext = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          estQ <= '0;
    else if (cmd.upd) estQ <= estNext;
  end

  assign est = estQ;

  // R3: a 1 never lowers the estimate
  p_up_dir_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.upd && cmd.up |=> estQ >= $past(estQ));
  // R3: a 0 never raises the estimate
  p_down_dir_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.upd && !cmd.up |=> estQ <= $past(estQ));
  // R6: no wrap from positive to negative
  p_no_wrap_hi_r6: assert property (@(posedge clk) disable iff (rst)
    cmd.upd && cmd.up && !estQ[W-1] |=> !estQ[W-1]);
  // R6: no wrap from negative to positive
  p_no_wrap_lo_r6: assert property (@(posedge clk) disable iff (rst)
    cmd.upd && !cmd.up && estQ[W-1] |=> estQ[W-1]);
  // R7: estimate frozen while disabled
  p_hold_est_r7: assert property (@(posedge clk) disable iff (rst)
    !cmd.upd |=> $stable(estQ));
endmodule

// File: rtl/adm_codec.sv
module adm_codec
  import adm_pkg::*;
#(
  parameter int W         = 16,
  parameter int STEP_MIN  = 16,
  parameter int MAX_SHIFT = 4,
  parameter int HIST_LEN  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleEn,
  input  logic signed [W-1:0] sampleIn,
  input  logic                decBitIn,
  output logic                encBit,
  output logic signed [W-1:0] encEstimate,
  output logic signed [W-1:0] decOut
);
  localparam int LANES = 2;  // lane 0 encodes, lane 1 decodes

  logic                laneBit [LANES];
  logic signed [W-1:0] laneEst [LANES];
  stepCmd_t            laneCmd [LANES];
  logic                encBitQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_enc
      assign laneBit[g] = (sampleIn >= laneEst[g]);
    end else begin : g_dec
      assign laneBit[g] = decBitIn;
    end

    adm_step_ctrl #(.MAX_SHIFT(MAX_SHIFT), .HIST_LEN(HIST_LEN)) u_ctrl (
      .clk(clk), .rst(rst), .en(sampleEn), .bitIn(laneBit[g]), .cmd(laneCmd[g]));

    adm_integ #(.W(W), .STEP_MIN(STEP_MIN)) u_integ (
      .clk(clk), .rst(rst), .cmd(laneCmd[g]), .est(laneEst[g]));
  end

  always_ff @(posedge clk) begin
    if (rst)           encBitQ <= 1'b0;
    else if (sampleEn) encBitQ <= laneBit[0];
  end

  assign encBit      = encBitQ;
  assign encEstimate = laneEst[0];
  assign decOut      = laneEst[1];

  // R2: latched bit reflects the previous edge's comparison
  p_bit_latch_r2: assert property (@(posedge clk) disable iff (rst)
    sampleEn |=> encBit == ($past(sampleIn) >= $past(encEstimate)));
  // R7: bit frozen while disabled
  p_bit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> $stable(encBit));
endmodule

// File: tb/adm_codec_tb.sv
`timescale 1ns/1ps
module adm_codec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleEn = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic decBitIn = 1'b0;
  logic encBit;
  logic signed [15:0] encEstimate, decOut;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int mEst, mShift;
  logic [3:0] mHist;
  logic mBit;

  always #2.5 clk = ~clk;

  adm_codec u_dut (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .sampleIn(sampleIn),
    .decBitIn(decBitIn), .encBit(encBit), .encEstimate(encEstimate),
    .decOut(decOut));

  localparam int NVEC = 24;
  localparam int VEC [NVEC] = '{
    1000, 2000, 4000, 8000, 12000, 9000, 3000, -2000,
    -9000, -15000, -20000, -18000, -6000, 0, 0, 0,
    500, -500, 500, -500, 25000, 25000, -25000, 100};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; sampleEn = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mEst = 0; mShift = 0; mHist = 4'b0101; mBit = 1'b0;
  endtask

  // drive one tick at a negedge, evaluate model, sample at next negedge
  task automatic doTick(input int s, input bit en);
    bit b;
    int st, ne;
    sampleIn = 16'(s);
    sampleEn = en;
    if (en) begin
      b  = (s >= mEst);
      st = 16 << mShift;
      ne = b ? mEst + st : mEst - st;
      if (ne > 32767) ne = 32767;
      if (ne < -32768) ne = -32768;
      mEst  = ne;
      mHist = {mHist[2:0], b};
      if (mHist == 4'b1111 || mHist == 4'b0000) begin
        if (mShift < 4) mShift++;
      end else if (mShift > 0) mShift--;
      mBit = b;
      decBitIn = b;
    end else begin
      decBitIn = ~decBitIn;  // must be ignored
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmpAll(input string tag);
    chk(encBit == mBit, {tag, " R2 encBit"}, int'(encBit), int'(mBit));
    chk(int'(encEstimate) == mEst, {tag, " R3 encEstimate"}, int'(encEstimate), mEst);
    chk(int'(decOut) == mEst, {tag, " R8 decOut"}, int'(decOut), mEst);
  endtask

  initial begin
    int minSeen;
    doReset();
    // R1: reset state
    chk(encBit == 1'b0, "R1 encBit reset", int'(encBit), 0);
    chk(encEstimate == 0, "R1 encEstimate reset", int'(encEstimate), 0);
    chk(decOut == 0, "R1 decOut reset", int'(decOut), 0);

    // R1/R3: first up move uses minimum step
    doTick(10000, 1'b1);
    chk(int'(encEstimate) == 16, "R1 first step minimum", int'(encEstimate), 16);
    // R4: run of ones grows step to its cap
    for (int i = 0; i < 7; i++) doTick(10000, 1'b1);
    chk(int'(encEstimate) == 784, "R4 step growth and cap", int'(encEstimate), 784);
    cmpAll("R4 ramp");
    // R5: mixed history shrinks step 256,128,64,32
    for (int i = 0; i < 4; i++) doTick(0, 1'b1);
    chk(int'(encEstimate) == 304, "R5 step decay", int'(encEstimate), 304);
    // R7: disabled ticks change nothing
    for (int i = 0; i < 3; i++) begin
      doTick(-30000, 1'b0);
      chk(int'(encEstimate) == 304, "R7 hold encEstimate", int'(encEstimate), 304);
      chk(int'(decOut) == 304, "R7 hold decOut", int'(decOut), 304);
      chk(encBit == 1'b0, "R7 hold encBit", int'(encBit), 0);
    end
    // R7: step exponent preserved across the gap (step 64)
    doTick(-30000, 1'b1);
    chk(int'(encEstimate) == 240, "R7 step kept over gap", int'(encEstimate), 240);
    cmpAll("R7 resume");

    // table of vectors, each held for several ticks, with an enable gap
    doReset();
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < 5; k++) begin
        doTick(VEC[v], (k != 2) || (v % 3 != 0));
        cmpAll("R8 table");
      end
    end

    // R6: positive clamp
    doReset();
    for (int i = 0; i < 200; i++) doTick(32767, 1'b1);
    chk(int'(encEstimate) == 32767, "R6 positive clamp", int'(encEstimate), 32767);
    cmpAll("R6 high");
    // R6: negative clamp
    minSeen = 0;
    for (int i = 0; i < 300; i++) begin
      doTick(-32768, 1'b1);
      if (int'(encEstimate) < minSeen) minSeen = int'(encEstimate);
      chk(int'(decOut) == mEst, "R6 R8 decoder tracks at low end", int'(decOut), mEst);
    end
    chk(minSeen == -32768, "R6 negative clamp", minSeen, -32768);
    cmpAll("R6 low");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule